// File: doc/BRIEF.md
# I2C Register Target with Read-Select Pointer

This block is an I2C target with a 10-bit device address. It sits in front of a small byte-wide register file. A controller writes by sending the two address bytes and then a register address. After that come one or more data bytes, and each further byte lands one address lower than the one before it.

Reads do not use the write pointer. A read starts from whatever address the controller has placed in a dedicated read-select register. The controller does this beforehand with an ordinary write.

During a read, the pointer moves only inside the six-register axis window, and there it follows a fixed non-linear loop. For any other address the pointer stays put. This lets repeated bytes drain the FIFO data port, and each byte taken from that port issues a single-cycle pop strobe to the FIFO. The bus lines are sampled with the system clock, and SDA is driven as an open-drain pull-down enable.

Top module: `i2c10_regtarget`

## Requirements
- R1: After reset the block does not pull SDA low and does not pulse the FIFO pop strobe.
- R2: With device address 0x2A5, the first address byte 0xF4 (pattern 11110, address bits 9:8, R/W=0 meaning write) and the second byte 0xA5 are each acknowledged by pulling SDA low in the ninth clock.
- R3: A first address byte whose bits 2:1 differ from address bits 9:8, or a second byte that differs from address bits 7:0, is not acknowledged. The remaining bytes of that transfer are not acknowledged and change no register.
- R4: In a write, the target acknowledges the register address byte and every data byte. Data byte k (k counted from 0) is stored at the register address minus k.
- R5: A read returns the register whose address is held in the read-select register at address 0x0E. That value is written by an ordinary write and keeps its value across STOP and later transfers until it is written again.
- R6: A read frame consists of START, 0xF4, 0xA5, a repeated START and 0xF5. The byte 0xF5 is acknowledged only if the same transfer already matched both write address bytes. Sent directly after a START, it is not acknowledged.
- R7: When the read starts inside the axis window (X low 0x04, X high 0x05, Y low 0x06, Y high 0x07, Z low 0x08, Z high 0x09), consecutive bytes follow the loop 0x07, 0x06, 0x05, 0x04, 0x09, 0x08 and then back to 0x07.
- R8: For any other start address, the read pointer holds. Address 0x0F returns the FIFO input and pulses the pop strobe for exactly one cycle per byte loaded. Addresses of 0x10 and above read as 0x00.
- R9: After a data byte that the controller answers with NACK, the target releases SDA. It drives nothing and pops nothing until the next START or STOP.
- R10: A STOP, even one in the middle of a byte, ends the transfer state. The next transfer is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, used to sample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| fifo_data_i | input | 8 | Head byte of the output FIFO |
| fifo_pop_o | output | 1 | One-cycle strobe: FIFO head consumed |

## Verification
The write path is exercised with a fourteen-byte descending burst that covers every ordinary register. Each register is then read back one at a time through the read-select register, which separates a decrementing write pointer from an incrementing or fixed one.

Reads are started at each of the six axis addresses and run for eight bytes, so the expected bytes wrap around the whole loop. A loop that runs the wrong way or skips a register shows up in these reads.

Repeated reads of a plain register, of an unmapped address and of the FIFO port tell a holding pointer apart from a moving one, and the pop count is compared with the number of bytes read. The remaining transfers use a wrong upper address, a wrong lower address, a read with no write phase and a STOP halfway through a byte, and each is checked for no acknowledge and for unchanged registers.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

    localparam logic [7:0] RSEL_ADDR = 8'h0E;
    localparam logic [7:0] FIFO_ADDR = 8'h0F;
    localparam logic [7:0] AXW_LO    = 8'h04;  // X low
    localparam logic [7:0] AXW_HI    = 8'h09;  // Z high
    localparam logic [7:0] AX_ZL     = 8'h08;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV1, ST_DEV2, ST_REG, ST_WDATA, ST_RDATA, ST_WAIT
    } st_e;

    typedef enum logic [1:0] {PH_BITS, PH_ACK, PH_MACK, PH_LOAD} ph_e;

    typedef struct packed {
        st_e        st;
        ph_e        ph;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic       oe;
        logic       hit;
        logic [7:0] wptr;
        logic [7:0] rptr;
        logic       pop;
    } prot_t;

    // Read-pointer step: axis loop Y_hi,Y_lo,X_hi,X_lo,Z_hi,Z_lo; hold elsewhere
    function automatic logic [7:0] rd_next(input logic [7:0] a);
        logic [7:0] r;
        if (a < AXW_LO || a > AXW_HI) r = a;
        else if (a == AXW_LO)          r = AXW_HI;
        else if (a == AX_ZL)           r = 8'h07;
        else                           r = a - 8'd1;
        return r;
    endfunction

endpackage

// File: rtl/i2c10_buscond.sv
module i2c10_buscond (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_s_o
);
    typedef struct packed {
        logic [2:0] scl;  // [0] first sync, [1] synced, [2] previous
        logic [2:0] sda;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.scl = {s_q.scl[1:0], scl_i};
        s_d.sda = {s_q.sda[1:0], sda_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{scl: 3'b111, sda: 3'b111};
        else         s_q <= s_d;
    end

    assign scl_rise_o = s_q.scl[1] & ~s_q.scl[2];
    assign scl_fall_o = ~s_q.scl[1] & s_q.scl[2];
    assign start_o    = s_q.scl[1] & s_q.scl[2] & s_q.sda[2] & ~s_q.sda[1];
    assign stop_o     = s_q.scl[1] & s_q.scl[2] & ~s_q.sda[2] & s_q.sda[1];
    assign sda_s_o    = s_q.sda[1];

endmodule

// File: rtl/i2c10_regfile.sv
module i2c10_regfile #(
    parameter int NREG = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       we_i,
    input  logic [7:0] waddr_i,
    input  logic [7:0] wdata_i,
    input  logic [7:0] raddr_i,
    output logic [7:0] rdata_o,
    output logic [7:0] rdsel_o,
    input  logic [7:0] fifo_data_i
);
    import i2c10_pkg::*;
    localparam int AW = $clog2(NREG);

    logic [7:0] mem_d [NREG];
    logic [7:0] mem_q [NREG];

    always_comb begin
        mem_d = mem_q;
        if (we_i && int'(waddr_i) < NREG && waddr_i != FIFO_ADDR)
            mem_d[waddr_i[AW-1:0]] = wdata_i;
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) mem_q[g] <= 8'h00;
                else         mem_q[g] <= mem_d[g];
            end
        end
    endgenerate

    always_comb begin
        if (raddr_i == FIFO_ADDR)       rdata_o = fifo_data_i;
        else if (int'(raddr_i) < NREG)  rdata_o = mem_q[raddr_i[AW-1:0]];
        else                            rdata_o = 8'h00;
    end

    assign rdsel_o = mem_q[RSEL_ADDR[AW-1:0]];

    assert_rsel_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!we_i || waddr_i != RSEL_ADDR) |=> $stable(rdsel_o));

endmodule

// File: rtl/i2c10_proto.sv
module i2c10_proto #(
    parameter logic [9:0] DEV_ADDR = 10'h2A5
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       sda_i,
    input  logic [7:0] rdata_i,
    input  logic [7:0] rdsel_i,
    output logic [7:0] raddr_o,
    output logic       we_o,
    output logic [7:0] waddr_o,
    output logic [7:0] wdata_o,
    output logic       sda_oe_o,
    output logic       pop_o
);
    import i2c10_pkg::*;

    prot_t q, n;
    logic [7:0] byte_in;

    assign byte_in = {q.sh[6:0], sda_i};
    assign raddr_o = q.rptr;

    always_comb begin
        n       = q;
        n.pop   = 1'b0;
        we_o    = 1'b0;
        waddr_o = q.wptr;
        wdata_o = byte_in;
        if (start_i) begin
            n.st = ST_DEV1; n.ph = PH_BITS; n.cnt = '0; n.oe = 1'b0;
        end else if (stop_i) begin
            n.st = ST_IDLE; n.ph = PH_BITS; n.cnt = '0; n.oe = 1'b0; n.hit = 1'b0;
        end else begin
            case (q.st)
                ST_IDLE, ST_WAIT: ;
                ST_RDATA: begin
                    case (q.ph)
                        PH_BITS: if (scl_fall_i) begin
                            if (q.cnt == 3'd7) begin
                                n.oe = 1'b0; n.ph = PH_MACK;
                            end else begin
                                n.cnt = q.cnt + 3'd1;
                                n.sh  = {q.sh[6:0], 1'b0};
                                n.oe  = ~q.sh[6];
                            end
                        end
                        PH_MACK: if (scl_rise_i) begin
                            if (sda_i) n.st = ST_WAIT;
                            else       n.ph = PH_LOAD;
                        end
                        default: if (scl_fall_i) begin
                            if (q.ph == PH_ACK && !q.oe) begin
                                n.oe = 1'b1;
                            end else begin
                                n.sh   = rdata_i;
                                n.oe   = ~rdata_i[7];
                                n.cnt  = '0;
                                n.ph   = PH_BITS;
                                n.pop  = (q.rptr == FIFO_ADDR);
                                n.rptr = rd_next(q.rptr);
                            end
                        end
                    endcase
                end
                default: begin
                    if (q.ph == PH_BITS) begin
                        if (scl_rise_i) begin
                            n.sh  = byte_in;
                            n.cnt = q.cnt + 3'd1;
                            if (q.cnt == 3'd7) begin
                                n.ph = PH_ACK;
                                case (q.st)
                                    ST_DEV1: begin
                                        if (byte_in[7:1] != {5'b11110, DEV_ADDR[9:8]})
                                            n.st = ST_WAIT;
                                        else if (!byte_in[0])
                                            n.st = ST_DEV2;
                                        else if (q.hit) begin
                                            n.st = ST_RDATA; n.rptr = rdsel_i;
                                        end else
                                            n.st = ST_WAIT;
                                    end
                                    ST_DEV2: begin
                                        if (byte_in == DEV_ADDR[7:0]) begin
                                            n.st = ST_REG; n.hit = 1'b1;
                                        end else
                                            n.st = ST_WAIT;
                                    end
                                    ST_REG: begin
                                        n.wptr = byte_in; n.st = ST_WDATA;
                                    end
                                    default: begin
                                        we_o   = 1'b1;
                                        n.wptr = q.wptr - 8'd1;
                                    end
                                endcase
                            end
                        end
                    end else if (scl_fall_i) begin
                        if (!q.oe) n.oe = 1'b1;
                        else begin
                            n.oe = 1'b0; n.ph = PH_BITS; n.cnt = '0;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: ST_IDLE, ph: PH_BITS, default: '0};
        else         q <= n;
    end

    assign sda_oe_o = q.oe;
    assign pop_o    = q.pop;

    assert_pop_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.pop |=> !q.pop);
    assert_pop_fifo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.pop |-> q.rptr == FIFO_ADDR);
    assert_idle_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_IDLE || q.st == ST_WAIT) |-> !q.oe);
    assert_stop_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !start_i) |=> (q.st == ST_IDLE && !q.hit));

endmodule

// File: rtl/i2c10_regtarget.sv
module i2c10_regtarget #(
    parameter logic [9:0] DEV_ADDR = 10'h2A5,
    parameter int         NREG     = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [7:0] fifo_data_i,
    output logic       fifo_pop_o
);
    logic       scl_rise, scl_fall, start, stop, sda_s;
    logic [7:0] raddr, rdata, rdsel, waddr, wdata;
    logic       we;

    i2c10_buscond i_cond (
        .clk_i, .rst_ni, .scl_i, .sda_i,
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start), .stop_o(stop), .sda_s_o(sda_s)
    );

    i2c10_proto #(.DEV_ADDR(DEV_ADDR)) i_proto (
        .clk_i, .rst_ni,
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start), .stop_i(stop), .sda_i(sda_s),
        .rdata_i(rdata), .rdsel_i(rdsel), .raddr_o(raddr),
        .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
        .sda_oe_o(sda_oe_o), .pop_o(fifo_pop_o)
    );

    i2c10_regfile #(.NREG(NREG)) i_regs (
        .clk_i, .rst_ni,
        .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
        .raddr_i(raddr), .rdata_o(rdata), .rdsel_o(rdsel),
        .fifo_data_i(fifo_data_i)
    );

endmodule

// File: tb/test_i2c10_regtarget.sv
module test_i2c10_regtarget;
    localparam int Q = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1;
    logic sda_oe, pop;
    logic [7:0] fifo_val = 8'h40;
    wire  sda_ln = sda_m & ~sda_oe;
    int   checks = 0, failures = 0, pops = 0;
    logic [7:0] model [16];
    logic [7:0] rbuf [16];
    bit   done = 0;

    always #5 clk = ~clk;

    i2c10_regtarget i_i2c10_regtarget (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_ln),
        .sda_oe_o(sda_oe), .fifo_data_i(fifo_val), .fifo_pop_o(pop)
    );

    always @(posedge clk) if (rst_n && pop) begin
        fifo_val <= fifo_val + 8'd1;
        pops++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start(); sda_m = 1; scl = 1; tick(); sda_m = 0; tick(); scl = 0; tick(); endtask
    task automatic bus_rstart(); sda_m = 1; tick(); scl = 1; tick(); sda_m = 0; tick(); scl = 0; tick(); endtask
    task automatic bus_stop(); sda_m = 0; tick(); scl = 1; tick(); sda_m = 1; tick(); tick(); endtask
    task automatic put_bit(input logic b); sda_m = b; tick(); scl = 1; tick(); tick(); scl = 0; tick(); endtask
    task automatic get_bit(output logic b); sda_m = 1; tick(); scl = 1; tick(); b = sda_ln; tick(); scl = 0; tick(); endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(nack);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) get_bit(b[i]);
        put_bit(nack);
    endtask

    // write n bytes from rbuf-independent wbuf starting at reg a (descending)
    task automatic wr_regs(input logic [7:0] a, input int n, input logic [7:0] wb [16], input string req);
        logic nk;
        int   bad = 0;
        bus_start();
        send_byte(8'hF4, nk); chk("R2 first addr byte ack", nk, 0);
        send_byte(8'hA5, nk); chk("R2 second addr byte ack", nk, 0);
        send_byte(a, nk); bad += nk;
        for (int i = 0; i < n; i++) begin send_byte(wb[i], nk); bad += nk; end
        bus_stop();
        chk(req, bad, 0);
    endtask

    task automatic set_rsel(input logic [7:0] a);
        logic [7:0] wb [16];
        wb[0] = a;
        wr_regs(8'h0E, 1, wb, "R5 read-select write acks");
    endtask

    task automatic rd_regs(input int n);
        logic nk;
        bus_start();
        send_byte(8'hF4, nk);
        send_byte(8'hA5, nk);
        bus_rstart();
        send_byte(8'hF5, nk); chk("R6 read byte ack after write phase", nk, 0);
        for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
        bus_stop();
    endtask

    function automatic logic [7:0] axis_step(input logic [7:0] a);
        if (a == 8'd4) return 8'd9;
        if (a == 8'd8) return 8'd7;
        return a - 8'd1;
    endfunction

    initial begin
        logic [7:0] wb [16];
        logic nk, b;
        int   p0;
        logic [7:0] base, a;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        chk("R1 sda released after reset", sda_oe, 0);
        chk("R1 no pop after reset", pop, 0);

        // R4: descending burst over registers 13..0
        for (int i = 0; i < 14; i++) begin
            wb[i] = 8'((i * 37 + 11) & 8'hFF);
            model[13 - i] = wb[i];
        end
        wr_regs(8'h0D, 14, wb, "R4 burst data acks");
        for (int r = 0; r < 14; r++) begin
            set_rsel(8'(r));
            rd_regs(1);
            chk($sformatf("R4 R5 reg %0d readback", r), rbuf[0], model[r]);
        end

        // R4: short burst at 3 lands at 3 then 2
        wb[0] = 8'hC3; wb[1] = 8'h5A; model[3] = 8'hC3; model[2] = 8'h5A;
        wr_regs(8'h03, 2, wb, "R4 short burst acks");
        set_rsel(8'h02); rd_regs(1); chk("R4 decrement second byte", rbuf[0], model[2]);
        set_rsel(8'h03); rd_regs(1); chk("R4 decrement first byte", rbuf[0], model[3]);

        // R7: axis loop from every entry point
        for (int s = 4; s <= 9; s++) begin
            set_rsel(8'(s));
            rd_regs(8);
            a = 8'(s);
            for (int k = 0; k < 8; k++) begin
                chk($sformatf("R7 start %0d byte %0d", s, k), rbuf[k], model[a]);
                a = axis_step(a);
            end
        end

        // R8: hold on plain register and unmapped address
        set_rsel(8'h02); rd_regs(3);
        for (int k = 0; k < 3; k++) chk("R8 plain register holds", rbuf[k], model[2]);
        set_rsel(8'h30); rd_regs(2);
        for (int k = 0; k < 2; k++) chk("R8 unmapped reads zero", rbuf[k], 0);

        // R5: value persists across transfers
        set_rsel(8'h0B); rd_regs(1); rd_regs(1);
        chk("R5 read-select persists", rbuf[0], model[11]);

        // R8: FIFO burst and pop count
        set_rsel(8'h0F);
        p0 = pops; base = fifo_val;
        rd_regs(4);
        for (int k = 0; k < 4; k++) chk("R8 fifo burst data", rbuf[k], 8'(base + 8'(k)));
        chk("R8 pop count", pops - p0, 4);

        // R9: after NACK the target stays off the bus
        p0 = pops;
        bus_start();
        send_byte(8'hF4, nk); send_byte(8'hA5, nk);
        bus_rstart();
        send_byte(8'hF5, nk);
        recv_byte(1'b1, rbuf[0]);
        begin
            int lows = 0;
            for (int i = 0; i < 9; i++) begin get_bit(b); lows += (b == 0); end
            chk("R9 sda released after nack", lows, 0);
        end
        chk("R9 single pop", pops - p0, 1);
        bus_stop();

        // R3: wrong upper bits, then wrong lower byte
        bus_start();
        send_byte(8'hF2, nk); chk("R3 upper mismatch nack", nk, 1);
        send_byte(8'hA5, nk); send_byte(8'h01, nk); send_byte(8'hEE, nk);
        chk("R3 trailing byte nack", nk, 1);
        bus_stop();
        bus_start();
        send_byte(8'hF4, nk); chk("R2 upper match ack", nk, 0);
        send_byte(8'hA4, nk); chk("R3 lower mismatch nack", nk, 1);
        send_byte(8'h01, nk); send_byte(8'hEE, nk);
        bus_stop();
        set_rsel(8'h01); rd_regs(1); chk("R3 register untouched", rbuf[0], model[1]);

        // R6: read without a write phase
        bus_start();
        send_byte(8'hF5, nk); chk("R6 bare read nack", nk, 1);
        bus_stop();

        // R10: STOP half way through a byte
        bus_start();
        send_byte(8'hF4, nk);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        wb[0] = 8'h77; model[1] = 8'h77;
        wr_regs(8'h01, 1, wb, "R10 fresh transfer after stop acks");
        rd_regs(1); chk("R10 write after aborted byte", rbuf[0], 8'h77);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule